// File: doc/BRIEF.md
# Watchdog and Clock-Settling Timer

This block is an 8-bit up-counter with a small control/status register. It serves three purposes. As a watchdog, its overflow requests a power-on reset of the system. As an interval timer, its overflow raises an interrupt. As a settling timer, it keeps the processor stalled after a change of the clock multiplier, so that the oscillator has time to settle before execution resumes.

The counter advances on ticks from a free-running prescaler of the peripheral clock. A 3-bit select field picks one of eight taps. Software reaches both registers over a simple single-cycle register bus.

When a frequency-control write changes the multiplier, the block starts a one-shot settling count. That count begins from the programmed start value and uses the programmed tap. When it overflows, the block releases the stall. It does not set the overflow flag, and it leaves the counter frozen at 0x00 until software loads it again. A write that only switches a divider is ignored.

Top module: `wdog_settle_timer`

## Requirements
- R1: After synchronous reset, the counter reads 0x00, the control register reads 0x00, and `cpu_stall`, `rst_req` and `irq` are low.
- R2: The bus address selects the register. Address 0 holds the counter and address 1 holds the control register. While the enable bit is set and no settling or freeze is active, the counter advances by one on each selected prescaler tick and wraps from 0xFF to 0x00. A bus write to address 0 loads the written value.
- R3: Control bits 2:0 select the tick period. The codes 0 through 7 give 1, 4, 16, 32, 64, 256, 1024 and 4096 clock cycles respectively.
- R4: Control bit 6 set selects watchdog mode. In this mode, an enabled overflow sets the overflow flag (control bit 7) and drives `rst_req` high for exactly one cycle. The counter keeps counting afterwards.
- R5: Control bit 6 clear selects interval mode. In this mode, an enabled overflow sets the overflow flag and drives `irq` high for exactly one cycle, never `rst_req`. The counter keeps counting afterwards.
- R6: A cycle with `freq_wr` and `freq_mult_chg` both high raises `cpu_stall` on the next cycle. The counter then counts from its current value on every selected tick, whether or not the enable bit is set. Starting from 0xF0 with code 0, the stall lasts 16 cycles.
- R7: A settling overflow drops `cpu_stall` and leaves the overflow flag unchanged, with no `rst_req` or `irq` pulse. The counter then holds 0x00, even with the enable bit set, until software writes the counter.
- R8: A `freq_wr` with `freq_mult_chg` low has no effect. A further multiplier write while a stall is in progress also has no effect and does not extend the stall.
- R9: With the enable bit (control bit 5) clear and no stall in progress, the counter holds its value and neither `rst_req` nor `irq` pulses.
- R10: Writing 0 to control bit 7 clears the overflow flag. Writing 1 leaves the flag unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R11: A counter write in a cycle that also carries a tick loads exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 1 | Register address: 0 is the counter, 1 is the control register |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| freq_wr | input | 1 | Frequency-control write strobe |
| freq_mult_chg | input | 1 | The frequency write changes the multiplier |
| cpu_stall | output | 1 | Stall request to the clock generator |
| rst_req | output | 1 | Power-on reset request pulse |
| irq | output | 1 | Interval interrupt pulse |

## Verification
The bench builds the block with its default package values: an 8-bit counter and a 12-bit prescaler. These make the full 4096-cycle tap reachable within the run, so the sweep measures the tick spacing of all eight select codes. With the 8-bit counter, a start value near 0xFF reaches overflow within a few ticks. This brings the watchdog, interval and settling overflows within a few dozen cycles, including the exact stall length from a chosen start value.

// File: rtl/wst_pkg.sv
package wst_pkg;

    localparam int unsigned CNT_W     = 8;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned NUM_TAPS  = 1 << SEL_W;
    localparam int unsigned MAX_SHIFT = 12;
    localparam int unsigned PRE_W     = MAX_SHIFT;

    localparam logic ADDR_COUNT = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HOLD   = 2'd2
    } wst_state_e;

    typedef struct packed {
        logic             ovf;
        logic             wdog;
        logic             en;
        logic [1:0]       rsvd;
        logic [SEL_W-1:0] sel;
    } wst_ctrl_t;

    function automatic int unsigned tap_shift(input int unsigned code);
        case (code)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            5:       return 8;
            6:       return 10;
            default: return MAX_SHIFT;
        endcase
    endfunction

endpackage

// File: rtl/wst_prescaler.sv
module wst_prescaler
    import wst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PRE_ONE;
    end

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int unsigned SH = tap_shift(i);
        if (SH == 0) begin : g_every
            assign taps[i] = 1'b1;
        end else begin : g_div
            assign taps[i] = &pre_q[SH-1:0];
        end
    end

    assign tick = taps[sel];
endmodule

// File: rtl/wst_regs.sv
module wst_regs
    import wst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             ovf_evt,
    output logic             cnt_wr,
    output logic             ctrl_en,
    output logic             ctrl_wdog,
    output logic [SEL_W-1:0] ctrl_sel,
    output logic             ovf_flag
);
    wst_ctrl_t ctrl_q;
    logic      ctrl_wr;
    logic      wdata_unused;

    assign cnt_wr       = bus_sel && bus_wr && (bus_addr == ADDR_COUNT);
    assign ctrl_wr      = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    assign wdata_unused = ^bus_wdata[4:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.wdog <= bus_wdata[6];
                ctrl_q.en   <= bus_wdata[5];
                ctrl_q.sel  <= bus_wdata[SEL_W-1:0];
                ctrl_q.ovf  <= ovf_evt || (ctrl_q.ovf && bus_wdata[7]);
            end else begin
                ctrl_q.ovf  <= ctrl_q.ovf || ovf_evt;
            end
            ctrl_q.rsvd <= '0;
        end
    end

    assign ctrl_en   = ctrl_q.en;
    assign ctrl_wdog = ctrl_q.wdog;
    assign ctrl_sel  = ctrl_q.sel;
    assign ovf_flag  = ctrl_q.ovf;

    always_comb begin
        if (bus_addr == ADDR_COUNT) bus_rdata = cnt_val;
        else                        bus_rdata = ctrl_q;
    end
endmodule

// File: rtl/wst_core.sv
module wst_core
    import wst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             wdog_mode,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             arm_req,
    output logic [CNT_W-1:0] cnt_q,
    output logic             stall,
    output logic             ovf_evt,
    output logic             rst_pulse,
    output logic             irq_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    wst_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_d;
    logic             arm, run_step, settle_step, settle_done;

    always_comb begin
        arm         = arm_req && (st_q != ST_SETTLE);
        settle_step = (st_q == ST_SETTLE) && tick && !cnt_wr;
        run_step    = (st_q == ST_RUN) && !arm && en && tick && !cnt_wr;
        settle_done = settle_step && (cnt_q == CNT_MAX);
        ovf_evt     = run_step && (cnt_q == CNT_MAX);

        cnt_d = cnt_q;
        if (cnt_wr)                       cnt_d = cnt_wdata;
        else if (settle_step || run_step) cnt_d = cnt_q + CNT_ONE;

        st_d = st_q;
        if (arm)                               st_d = ST_SETTLE;
        else if (settle_done)                  st_d = ST_HOLD;
        else if ((st_q == ST_HOLD) && cnt_wr)  st_d = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_RUN;
            cnt_q     <= '0;
            rst_pulse <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            rst_pulse <= ovf_evt && wdog_mode;
            irq_pulse <= ovf_evt && !wdog_mode;
        end
    end

    assign stall = (st_q == ST_SETTLE);
endmodule

// File: rtl/wdog_settle_timer.sv
module wdog_settle_timer
    import wst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       freq_wr,
    input  logic       freq_mult_chg,
    output logic       cpu_stall,
    output logic       rst_req,
    output logic       irq
);
    logic             tick;
    logic             cnt_wr;
    logic             ctrl_en;
    logic             ctrl_wdog;
    logic [SEL_W-1:0] ctrl_sel;
    logic             ovf_flag;
    logic             ovf_evt;
    logic [CNT_W-1:0] cnt_q;

    wst_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_sel),
        .tick (tick)
    );

    wst_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_q),
        .ovf_evt   (ovf_evt),
        .cnt_wr    (cnt_wr),
        .ctrl_en   (ctrl_en),
        .ctrl_wdog (ctrl_wdog),
        .ctrl_sel  (ctrl_sel),
        .ovf_flag  (ovf_flag)
    );

    wst_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .en        (ctrl_en),
        .wdog_mode (ctrl_wdog),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (bus_wdata[CNT_W-1:0]),
        .arm_req   (freq_wr && freq_mult_chg),
        .cnt_q     (cnt_q),
        .stall     (cpu_stall),
        .ovf_evt   (ovf_evt),
        .rst_pulse (rst_req),
        .irq_pulse (irq)
    );
endmodule

// File: rtl/wst_checker.sv
module wst_checker
    import wst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf_flag,
    input logic             ctrl_en,
    input logic             cnt_wr,
    input logic             freq_wr,
    input logic             freq_mult_chg,
    input logic             cpu_stall,
    input logic             rst_req,
    input logic             irq
);
    assert_rst_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ovf_flag);

    assert_rst_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_irq_not_rst_R5: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && irq));

    assert_stall_from_mult_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |-> $past(freq_wr && freq_mult_chg));

    assert_release_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_stall) |-> (cnt == '0 && !rst_req && !irq));

    assert_disabled_holds_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!ctrl_en) && $past(!cpu_stall) && $past(!cnt_wr)) |-> $stable(cnt));
endmodule

bind wdog_settle_timer wst_checker u_wst_chk (
    .clk           (clk),
    .rst           (rst),
    .cnt           (cnt_q),
    .ovf_flag      (ovf_flag),
    .ctrl_en       (ctrl_en),
    .cnt_wr        (cnt_wr),
    .freq_wr       (freq_wr),
    .freq_mult_chg (freq_mult_chg),
    .cpu_stall     (cpu_stall),
    .rst_req       (rst_req),
    .irq           (irq)
);

// File: tb/wdog_settle_timer_bench.sv
module wdog_settle_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       freq_wr = 1'b0;
    logic       freq_mult_chg = 1'b0;
    logic       cpu_stall;
    logic       rst_req;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit seen_edge = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdog_settle_timer u_wdog_settle_timer (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .freq_wr(freq_wr), .freq_mult_chg(freq_mult_chg),
        .cpu_stall(cpu_stall), .rst_req(rst_req), .irq(irq)
    );

    // behavioural reference model
    int m_cnt, m_pre, m_cks, m_phase;   // phase: 0 normal, 1 settling, 2 frozen
    bit m_en, m_wd, m_flag, m_rst, m_irq;

    function automatic int period_of(input int code);
        int p [8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
        return p[code];
    endfunction

    always @(posedge clk) begin
        seen_edge <= 1'b1;
        if (rst) begin
            m_cnt = 0; m_pre = 0; m_cks = 0; m_phase = 0;
            m_en = 0; m_wd = 0; m_flag = 0; m_rst = 0; m_irq = 0;
        end else begin
            bit tk, arm, cw, rw, ovf, fin;
            tk  = ((m_pre + 1) % period_of(m_cks)) == 0;
            m_pre = (m_pre + 1) % 4096;
            arm = freq_wr && freq_mult_chg && m_phase != 1;
            cw  = bus_sel && bus_wr && !bus_addr;
            rw  = bus_sel && bus_wr && bus_addr;
            ovf = 0; fin = 0;
            if (cw) m_cnt = bus_wdata;
            else if (m_phase == 1 && tk) begin
                if (m_cnt == 255) begin m_cnt = 0; fin = 1; end
                else m_cnt++;
            end else if (m_phase == 0 && !arm && m_en && tk) begin
                if (m_cnt == 255) begin m_cnt = 0; ovf = 1; end
                else m_cnt++;
            end
            m_rst = ovf && m_wd;
            m_irq = ovf && !m_wd;
            if (arm) m_phase = 1;
            else if (fin) m_phase = 2;
            else if (m_phase == 2 && cw) m_phase = 0;
            if (rw) begin
                m_wd = bus_wdata[6]; m_en = bus_wdata[5]; m_cks = bus_wdata[2:0];
                m_flag = ovf || (m_flag && bus_wdata[7]);
            end else m_flag = m_flag || ovf;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (seen_edge && !done) begin
            if (bus_addr == 1'b0) check("R2 counter read", bus_rdata, m_cnt);
            else check("R10 control read", bus_rdata,
                       {m_flag, m_wd, m_en, 2'b00, m_cks[2:0]});
            check("R6 stall", cpu_stall, m_phase == 1);
            check("R4 rst_req", rst_req, m_rst);
            check("R5 irq", irq, m_irq);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0; bus_addr = 0;
    endtask

    task automatic rd(input logic a, output int v);
        bus_addr = a; #1; v = bus_rdata; bus_addr = 0; #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int v, v2, cnt_hi, gap;
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        rd(0, v); check("R1 counter after reset", v, 0);
        rd(1, v); check("R1 control after reset", v, 0);
        check("R1 outputs after reset", {cpu_stall, rst_req, irq}, 0);

        // R3 tick spacing per select code
        for (int c = 0; c < 8; c++) begin
            wr(1, 8'h20 | c[7:0]);
            wr(0, 8'h00);
            rd(0, v);
            for (int k = 0; k < 5000; k++) begin step(); rd(0, v2); if (v2 != v) break; end
            gap = 0; v = v2;
            for (int k = 0; k < 5000; k++) begin step(); gap++; rd(0, v2); if (v2 != v) break; end
            check($sformatf("R3 period code %0d", c), gap, period_of(c));
        end

        // R4 watchdog overflow
        wr(1, 8'h60); wr(0, 8'hFC);
        cnt_hi = 0;
        for (int k = 0; k < 12; k++) begin step(); if (rst_req) cnt_hi++; end
        check("R4 single rst pulse", cnt_hi, 1);
        rd(1, v); check("R4 flag set", v[7], 1);
        rd(0, v); check("R4 counting continues", v > 0, 1);

        // R5 interval overflow
        wr(1, 8'h20); wr(0, 8'hFC);
        cnt_hi = 0; v2 = 0;
        for (int k = 0; k < 12; k++) begin step(); if (irq) cnt_hi++; if (rst_req) v2++; end
        check("R5 single irq pulse", cnt_hi, 1);
        check("R5 no rst pulse", v2, 0);

        // R10 flag clearing rules
        wr(1, 8'hA0); rd(1, v); check("R10 write one keeps flag", v[7], 1);
        wr(1, 8'h00); rd(1, v); check("R10 write zero clears", v, 8'h00);
        wr(1, 8'h80); rd(1, v); check("R10 write one on clear flag", v, 8'h00);
        wr(1, 8'h20); wr(0, 8'hFF);
        bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'h20; step();
        bus_sel = 0; bus_wr = 0; bus_addr = 0;
        rd(1, v); check("R10 overflow beats clear", v[7], 1);

        // R9 disabled counter holds
        wr(1, 8'h00); wr(0, 8'h33);
        cnt_hi = 0;
        for (int k = 0; k < 30; k++) begin step(); if (rst_req || irq) cnt_hi++; end
        rd(0, v); check("R9 counter held", v, 8'h33);
        check("R9 no pulses", cnt_hi, 0);

        // R11 write beats tick
        wr(1, 8'h20); wr(0, 8'h40);
        rd(0, v); check("R11 written value loaded", v, 8'h40);

        // R8 divider-only change ignored
        wr(1, 8'h00);
        freq_wr = 1; freq_mult_chg = 0; step(); freq_wr = 0;
        cnt_hi = 0;
        for (int k = 0; k < 5; k++) begin step(); if (cpu_stall) cnt_hi++; end
        check("R8 divider-only no stall", cnt_hi, 0);

        // R6/R7 settling sequence
        wr(0, 8'hF0);
        freq_wr = 1; freq_mult_chg = 1; step(); freq_wr = 0; freq_mult_chg = 0;
        check("R6 stall raised", cpu_stall, 1);
        cnt_hi = 0; v2 = 0;
        for (int k = 0; k < 100; k++) begin
            if (cpu_stall) cnt_hi++;
            if (rst_req || irq) v2++;
            if (k == 3) begin freq_wr = 1; freq_mult_chg = 1; end
            else begin freq_wr = 0; freq_mult_chg = 0; end
            step();
            if (!cpu_stall) break;
        end
        freq_wr = 0; freq_mult_chg = 0;
        check("R6 stall length", cnt_hi, 16);
        check("R7 no pulses on release", v2, 0);
        rd(0, v); check("R7 counter zero", v, 0);
        rd(1, v); check("R7 flag untouched", v[7], 0);
        wr(1, 8'h20);
        repeat (40) step();
        rd(0, v); check("R7 frozen while enabled", v, 0);
        wr(0, 8'h10);
        repeat (5) step();
        rd(0, v); check("R7 resumes after write", v, 8'h15);

        repeat (4) step();
        finish_run();
    end
endmodule